// File: doc/BRIEF.md
# Thread Block Dispatcher

This block hands the thread blocks of a single kernel launch to a set of streaming multiprocessors (SMs). A launch gives three values: the number of blocks, the threads per block, and a resource cost per warp. The block rounds the thread count up to whole 32-thread warps. It then offers blocks one at a time on a valid/ready assign port, each offer naming an SM and a block index. Each SM reports a finished block with a one-cycle retire pulse on its own bit.

An SM can take a new block only when three limits all allow it. The first is a cap on resident blocks per SM. The second is a cap on resident warps per SM. The third is a per-SM resource pool that the resident warps, times the launch cost, must not exceed. When more than one SM can take a block, a rotating priority chooses among them. A freed slot can be refilled in the cycle in which it is freed. When every block has been handed out and retired, the block raises a done flag and returns to idle. A launch that can never run is refused with an error flag.

Top module: `block_dispatch`

## Requirements
- R1: A launch is taken only while `busy` is low; a launch pulse while busy has no effect on the running kernel. Each block occupies ceil(threads/32) warp slots.
- R2: A launch is refused if any of these holds: the thread count is 0; it needs more than 64 warps; or one block's warps times the cost exceed `RES_POOL`. On a refusal `err` is 1, `busy` stays 0 and nothing is offered. `err` clears on the next launch that is taken.
- R3: No SM ever holds more than 16 resident blocks (`BLK_CAP`). With 2-warp blocks each SM fills to exactly 16 blocks and 32 warps.
- R4: No SM ever holds more than 64 resident warps (`WARP_CAP`). With 8-warp blocks each SM fills to exactly 8 blocks and 64 warps.
- R5: An SM receives a block only if (its resident warps + warps per block) × cost ≤ `RES_POOL`. A cost of 0 imposes no limit from the pool.
- R6: Once `asn_valid` is high, it stays high with `asn_sm` and `asn_block` unchanged until `asn_ready` accepts the offer. Block indices are offered in order 0, 1, 2, … with no gaps.
- R7: Among the SMs that can take a block, the first one after the SM granted last wins, wrapping around. After reset the search starts at SM 0.
- R8: A retire pulse on an SM that holds at least one block removes one block and its warps at that clock edge. At the same edge an offer to that SM may be formed from the freed room.
- R9: `done` rises one cycle after the last block has been accepted and retired, and `busy` falls with it. A launch with zero blocks sets `done` one cycle after it is taken. `done` holds until the next launch is taken.
- R10: After reset `asn_valid`, `busy`, `done` and `err` are 0, and every resident count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| launch_valid | input | 1 | One-cycle launch request |
| launch_blocks | input | CNT_W | Number of blocks in the launch |
| launch_threads | input | TPB_W | Threads per block |
| launch_cost | input | COST_W | Resource units reserved per resident warp |
| retire | input | NUM_SM | One-cycle completion pulse, one bit per SM |
| asn_ready | input | 1 | Consumer accepts the current offer |
| asn_valid | output | 1 | An assignment is offered |
| asn_sm | output | SM_W | Target SM of the offer |
| asn_block | output | CNT_W | Block index of the offer |
| busy | output | 1 | A launch is in progress |
| done | output | 1 | Last launch fully assigned and retired |
| err | output | 1 | Last launch was refused |
| res_blocks | output | NUM_SM*BCNT_W | Resident block count per SM, SM 0 in the low field |
| res_warps | output | NUM_SM*WCNT_W | Resident warp count per SM, SM 0 in the low field |

## Verification
The bench builds the block with three SMs, the default caps of 16 blocks and 64 warps, and a resource pool of 256 units. With an odd SM count, the rotating priority must wrap around at a boundary that is not a power of two. With the small pool, a cost of 8 units per warp makes the pool the limit at 4 eight-warp blocks per SM. With a cost of 0, the same build reaches the block cap with 2-warp blocks and the warp cap with 8-warp blocks.

// File: rtl/bd_pkg.sv
package bd_pkg;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} bd_state_e;

  // Whole warps needed for a thread count.
  function automatic int unsigned warps_of(input int unsigned thr, input int unsigned wsz);
    return (thr + wsz - 1) / wsz;
  endfunction

  // One more block of nw warps fits next to blk blocks / wrp warps.
  function automatic logic slot_fits(input int unsigned blk, input int unsigned wrp,
                                     input int unsigned nw, input int unsigned cost,
                                     input int unsigned bcap, input int unsigned wcap,
                                     input int unsigned pool);
    logic ok;
    ok = (blk + 1 <= bcap) && (wrp + nw <= wcap) && ((wrp + nw) * cost <= pool);
    return ok;
  endfunction

  // A launch whose single block can never fit an empty SM.
  function automatic logic launch_bad(input int unsigned nw, input int unsigned cost,
                                      input int unsigned wcap, input int unsigned pool);
    return (nw == 0) || (nw > wcap) || (nw * cost > pool);
  endfunction

endpackage

// File: rtl/bd_launch_chk.sv
module bd_launch_chk #(
  parameter int unsigned TPB_W    = 12,
  parameter int unsigned COST_W   = 8,
  parameter int unsigned WARP_SZ  = 32,
  parameter int unsigned WARP_CAP = 64,
  parameter int unsigned RES_POOL = 1024,
  localparam int unsigned WCNT_W  = $clog2(WARP_CAP + 1)
) (
  input  logic [TPB_W-1:0]  threads,
  input  logic [COST_W-1:0] cost,
  output logic [WCNT_W-1:0] nwarps,
  output logic              bad
);
  int unsigned nw_full;

  always_comb begin
    nw_full = bd_pkg::warps_of(32'(threads), WARP_SZ);
    bad     = bd_pkg::launch_bad(nw_full, 32'(cost), WARP_CAP, RES_POOL);
    nwarps  = WCNT_W'(nw_full);
  end
endmodule

// File: rtl/bd_sm_slot.sv
module bd_sm_slot #(
  parameter int unsigned BLK_CAP  = 16,
  parameter int unsigned WARP_CAP = 64,
  parameter int unsigned RES_POOL = 1024,
  parameter int unsigned COST_W   = 8,
  localparam int unsigned BCNT_W  = $clog2(BLK_CAP + 1),
  localparam int unsigned WCNT_W  = $clog2(WARP_CAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              retire,
  input  logic [WCNT_W-1:0] nwarps,
  input  logic [COST_W-1:0] cost,
  output logic [BCNT_W-1:0] blk_cnt,
  output logic [WCNT_W-1:0] wrp_cnt,
  output logic              fits
);
  logic [BCNT_W-1:0] blk_q;
  logic [WCNT_W-1:0] wrp_q;
  logic              freed;
  int unsigned       blk_net, wrp_net;

  // A pulse on an empty SM frees nothing.
  assign freed = retire && (blk_q != '0);

  always_comb begin
    blk_net = 32'(blk_q) - (freed ? 32'd1 : 32'd0);
    wrp_net = 32'(wrp_q) - (freed ? 32'(nwarps) : 32'd0);
    fits    = bd_pkg::slot_fits(blk_net, wrp_net, 32'(nwarps), 32'(cost),
                                BLK_CAP, WARP_CAP, RES_POOL);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q <= '0;
      wrp_q <= '0;
    end else begin
      blk_q <= BCNT_W'(blk_net + (take ? 32'd1 : 32'd0));
      wrp_q <= WCNT_W'(wrp_net + (take ? 32'(nwarps) : 32'd0));
    end
  end

  assign blk_cnt = blk_q;
  assign wrp_cnt = wrp_q;
endmodule

// File: rtl/bd_rr_pick.sv
module bd_rr_pick #(
  parameter int unsigned N       = 4,
  localparam int unsigned IDX_W  = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  input  logic             adv,
  output logic [N-1:0]     gnt,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] last_q;
  logic             hit;

  always_comb begin
    gnt = '0;
    idx = '0;
    hit = 1'b0;
    for (int o = 1; o <= int'(N); o++) begin
      int unsigned c;
      c = 32'(last_q) + 32'(o);
      if (c >= N) c = c - N;
      if (!hit && req[c]) begin
        hit    = 1'b1;
        gnt[c] = 1'b1;
        idx    = IDX_W'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   last_q <= IDX_W'(N - 1);
    else if (adv) last_q <= idx;
  end
endmodule

// File: rtl/block_dispatch.sv
module block_dispatch #(
  parameter int unsigned NUM_SM   = 4,
  parameter int unsigned BLK_CAP  = 16,
  parameter int unsigned WARP_CAP = 64,
  parameter int unsigned WARP_SZ  = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TPB_W    = 12,
  parameter int unsigned COST_W   = 8,
  parameter int unsigned RES_POOL = 1024,
  localparam int unsigned SM_W    = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int unsigned BCNT_W  = $clog2(BLK_CAP + 1),
  localparam int unsigned WCNT_W  = $clog2(WARP_CAP + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       launch_valid,
  input  logic [CNT_W-1:0]           launch_blocks,
  input  logic [TPB_W-1:0]           launch_threads,
  input  logic [COST_W-1:0]          launch_cost,
  input  logic [NUM_SM-1:0]          retire,
  input  logic                       asn_ready,
  output logic                       asn_valid,
  output logic [SM_W-1:0]            asn_sm,
  output logic [CNT_W-1:0]           asn_block,
  output logic                       busy,
  output logic                       done,
  output logic                       err,
  output logic [NUM_SM*BCNT_W-1:0]   res_blocks,
  output logic [NUM_SM*WCNT_W-1:0]   res_warps
);
  import bd_pkg::*;

  bd_state_e         st_q;
  logic [CNT_W-1:0]  total_q, next_q, asn_blk_q;
  logic [WCNT_W-1:0] nw_q;
  logic [COST_W-1:0] cost_q;
  logic [SM_W-1:0]   asn_sm_q;
  logic              asn_valid_q, done_q, err_q;

  // Named internal events
  logic              launch_take, asn_fire, offer_go, run_over, all_empty;
  logic [WCNT_W-1:0] chk_nw;
  logic              chk_bad;
  logic [NUM_SM-1:0] pick_req, pick_gnt, slot_take;
  logic [SM_W-1:0]   pick_idx;
  logic [BCNT_W-1:0] blk_cnt [NUM_SM];
  logic [WCNT_W-1:0] wrp_cnt [NUM_SM];

  assign launch_take = launch_valid && (st_q == ST_IDLE);
  assign asn_fire    = asn_valid_q && asn_ready;

  bd_launch_chk #(
    .TPB_W(TPB_W), .COST_W(COST_W), .WARP_SZ(WARP_SZ),
    .WARP_CAP(WARP_CAP), .RES_POOL(RES_POOL)
  ) u_launch (
    .threads(launch_threads), .cost(launch_cost), .nwarps(chk_nw), .bad(chk_bad)
  );

  for (genvar g = 0; g < NUM_SM; g++) begin : g_slot
    assign slot_take[g] = asn_fire && (asn_sm_q == SM_W'(g));
    bd_sm_slot #(
      .BLK_CAP(BLK_CAP), .WARP_CAP(WARP_CAP), .RES_POOL(RES_POOL), .COST_W(COST_W)
    ) u_slot (
      .clk(clk), .rst_n(rst_n), .take(slot_take[g]), .retire(retire[g]),
      .nwarps(nw_q), .cost(cost_q), .blk_cnt(blk_cnt[g]), .wrp_cnt(wrp_cnt[g]),
      .fits(pick_req[g])
    );
    assign res_blocks[g*BCNT_W +: BCNT_W] = blk_cnt[g];
    assign res_warps[g*WCNT_W +: WCNT_W]  = wrp_cnt[g];
  end

  always_comb begin
    all_empty = 1'b1;
    for (int i = 0; i < int'(NUM_SM); i++)
      if (blk_cnt[i] != '0) all_empty = 1'b0;
  end

  assign offer_go = (st_q == ST_RUN) && !asn_valid_q && (next_q != total_q) && (|pick_req);
  assign run_over = (st_q == ST_RUN) && (next_q == total_q) && !asn_valid_q && all_empty;

  bd_rr_pick #(.N(NUM_SM)) u_pick (
    .clk(clk), .rst_n(rst_n), .req(pick_req), .adv(offer_go),
    .gnt(pick_gnt), .idx(pick_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      total_q     <= '0;
      next_q      <= '0;
      nw_q        <= '0;
      cost_q      <= '0;
      asn_valid_q <= 1'b0;
      asn_sm_q    <= '0;
      asn_blk_q   <= '0;
      done_q      <= 1'b0;
      err_q       <= 1'b0;
    end else begin
      if (launch_take) begin
        done_q <= 1'b0;
        err_q  <= chk_bad;
        if (!chk_bad) begin
          st_q    <= ST_RUN;
          total_q <= launch_blocks;
          next_q  <= '0;
          nw_q    <= chk_nw;
          cost_q  <= launch_cost;
        end
      end else if (run_over) begin
        st_q   <= ST_IDLE;
        done_q <= 1'b1;
      end

      if (asn_fire) begin
        asn_valid_q <= 1'b0;
        next_q      <= next_q + 1'b1;
      end else if (offer_go) begin
        asn_valid_q <= 1'b1;
        asn_sm_q    <= pick_idx;
        asn_blk_q   <= next_q;
      end
    end
  end

  assign asn_valid = asn_valid_q;
  assign asn_sm    = asn_sm_q;
  assign asn_block = asn_blk_q;
  assign busy      = (st_q == ST_RUN);
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/bd_checker.sv
module bd_checker #(
  parameter int unsigned NUM_SM   = 4,
  parameter int unsigned BLK_CAP  = 16,
  parameter int unsigned WARP_CAP = 64,
  parameter int unsigned CNT_W    = 16,
  localparam int unsigned SM_W    = (NUM_SM > 1) ? $clog2(NUM_SM) : 1,
  localparam int unsigned BCNT_W  = $clog2(BLK_CAP + 1),
  localparam int unsigned WCNT_W  = $clog2(WARP_CAP + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     asn_valid,
  input logic                     asn_ready,
  input logic [SM_W-1:0]          asn_sm,
  input logic [CNT_W-1:0]         asn_block,
  input logic                     busy,
  input logic                     done,
  input logic                     err,
  input logic [NUM_SM*BCNT_W-1:0] res_blocks,
  input logic [NUM_SM*WCNT_W-1:0] res_warps,
  input logic [NUM_SM-1:0]        pick_gnt
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (asn_valid && !asn_ready) |=> (asn_valid && $stable(asn_sm) && $stable(asn_block)));

  p_onehot_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_gnt));

  p_err_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!asn_valid && !busy));

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !asn_valid));

  for (genvar g = 0; g < NUM_SM; g++) begin : g_caps
    p_blk_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      32'(res_blocks[g*BCNT_W +: BCNT_W]) <= BLK_CAP);
    p_warp_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      32'(res_warps[g*WCNT_W +: WCNT_W]) <= WARP_CAP);
  end
endmodule

bind block_dispatch bd_checker #(
  .NUM_SM(NUM_SM), .BLK_CAP(BLK_CAP), .WARP_CAP(WARP_CAP), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .asn_valid(asn_valid), .asn_ready(asn_ready),
  .asn_sm(asn_sm), .asn_block(asn_block), .busy(busy), .done(done), .err(err),
  .res_blocks(res_blocks), .res_warps(res_warps), .pick_gnt(pick_gnt)
);

// File: tb/block_dispatch_bench.sv
module block_dispatch_bench;
  localparam int NSM  = 3;
  localparam int CW   = 16;
  localparam int TW   = 12;
  localparam int KW   = 8;
  localparam int BW   = 5;
  localparam int WW   = 7;
  localparam int SW   = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic            launch_valid;
  logic [CW-1:0]   launch_blocks;
  logic [TW-1:0]   launch_threads;
  logic [KW-1:0]   launch_cost;
  logic [NSM-1:0]  retire;
  logic            asn_ready;
  logic            asn_valid;
  logic [SW-1:0]   asn_sm;
  logic [CW-1:0]   asn_block;
  logic            busy, done, err;
  logic [NSM*BW-1:0] res_blocks;
  logic [NSM*WW-1:0] res_warps;

  int checks = 0, errors = 0;
  int exp_id = 0, n_fire = 0;
  int hist [8];
  bit finished = 0;

  block_dispatch #(
    .NUM_SM(NSM), .BLK_CAP(16), .WARP_CAP(64), .WARP_SZ(32),
    .CNT_W(CW), .TPB_W(TW), .COST_W(KW), .RES_POOL(256)
  ) u_block_dispatch (
    .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid), .launch_blocks(launch_blocks),
    .launch_threads(launch_threads), .launch_cost(launch_cost), .retire(retire),
    .asn_ready(asn_ready), .asn_valid(asn_valid), .asn_sm(asn_sm), .asn_block(asn_block),
    .busy(busy), .done(done), .err(err), .res_blocks(res_blocks), .res_warps(res_warps)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int blk_of(input int i);
    return int'(res_blocks[i*BW +: BW]);
  endfunction

  function automatic int wrp_of(input int i);
    return int'(res_warps[i*WW +: WW]);
  endfunction

  // Advance to the next falling edge; log any handshake that completed.
  task automatic step();
    bit f;
    int s, b;
    f = asn_valid && asn_ready;
    s = int'(asn_sm);
    b = int'(asn_block);
    @(negedge clk);
    if (f) begin
      chk("R6 block index order", b, exp_id);
      if (n_fire < 8) hist[n_fire] = s;
      exp_id++;
      n_fire++;
    end
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_launch(input int nb, input int thr, input int cost);
    launch_blocks  = CW'(nb);
    launch_threads = TW'(thr);
    launch_cost    = KW'(cost);
    exp_id = 0;
    n_fire = 0;
    launch_valid = 1'b1;
    step();
    launch_valid = 1'b0;
  endtask

  task automatic drain();
    asn_ready = 1'b1;
    for (int k = 0; k < 4000 && !done; k++) begin
      for (int i = 0; i < NSM; i++) retire[i] = (blk_of(i) > 0);
      step();
      retire = '0;
    end
  endtask

  task automatic t_reset();
    chk("R10 asn_valid", int'(asn_valid), 0);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 err", int'(err), 0);
    chk("R10 counts", int'(res_blocks) + int'(res_warps), 0);
  endtask

  task automatic t_block_cap();
    asn_ready = 1'b1;
    do_launch(100, 64, 0);
    steps(120);
    for (int i = 0; i < NSM; i++) begin
      chk("R3 blocks at cap", blk_of(i), 16);
      chk("R3 warps with 2-warp blocks", wrp_of(i), 32);
    end
    chk("R3 offers accepted", n_fire, 48);
    for (int i = 0; i < 6; i++) chk("R7 rotation", hist[i], i % NSM);
    // R1: launch while busy is ignored
    launch_blocks = CW'(5); launch_threads = TW'(256); launch_valid = 1'b1;
    step();
    launch_valid = 1'b0;
    chk("R1 still busy", int'(busy), 1);
    // R8: retire on full SM1 refills it from the same edge
    asn_ready = 1'b0;
    retire = 3'b010;
    step();
    retire = '0;
    chk("R8 offer rises", int'(asn_valid), 1);
    chk("R8 offer target", int'(asn_sm), 1);
    chk("R8 blocks freed", blk_of(1), 15);
    chk("R8 warps freed", wrp_of(1), 30);
    steps(3);
    chk("R6 held valid", int'(asn_valid), 1);
    chk("R6 held index", int'(asn_block), 48);
    chk("R6 held target", int'(asn_sm), 1);
    asn_ready = 1'b1;
    steps(2);
    chk("R1 block size kept", wrp_of(1), 32);
    chk("R8 refilled", blk_of(1), 16);
    drain();
    chk("R9 done", int'(done), 1);
    chk("R9 busy low", int'(busy), 0);
    chk("R9 all blocks", n_fire, 100);
    steps(2);
    chk("R9 done holds", int'(done), 1);
  endtask

  task automatic t_warp_cap();
    do_launch(40, 225, 0);
    chk("R9 done cleared", int'(done), 0);
    chk("R1 busy", int'(busy), 1);
    steps(80);
    for (int i = 0; i < NSM; i++) begin
      chk("R4 blocks", blk_of(i), 8);
      chk("R4 warps at cap", wrp_of(i), 64);
    end
    chk("R4 offers accepted", n_fire, 24);
    drain();
    chk("R9 done", int'(done), 1);
    chk("R9 all blocks", n_fire, 40);
  endtask

  task automatic t_budget();
    do_launch(30, 256, 8);
    steps(60);
    for (int i = 0; i < NSM; i++) begin
      chk("R5 blocks under pool", blk_of(i), 4);
      chk("R5 warps under pool", wrp_of(i), 32);
    end
    chk("R5 offers accepted", n_fire, 12);
    drain();
    chk("R5 all blocks", n_fire, 30);
  endtask

  task automatic t_reject();
    do_launch(5, 0, 0);
    chk("R2 zero threads err", int'(err), 1);
    chk("R2 zero threads idle", int'(busy), 0);
    steps(3);
    chk("R2 no offer", int'(asn_valid), 0);
    chk("R2 no handshake", n_fire, 0);
    do_launch(5, 2049, 0);
    chk("R2 65 warps err", int'(err), 1);
    do_launch(5, 64, 200);
    chk("R2 over pool err", int'(err), 1);
    steps(3);
    chk("R2 counts untouched", int'(res_blocks), 0);
    do_launch(3, 33, 0);
    chk("R2 err cleared", int'(err), 0);
    steps(10);
    for (int i = 0; i < NSM; i++) chk("R1 33 threads -> 2 warps", wrp_of(i), 2);
    drain();
    chk("R9 done", int'(done), 1);
  endtask

  task automatic t_zero();
    do_launch(0, 32, 0);
    chk("R9 zero launch busy", int'(busy), 1);
    chk("R9 zero launch not yet done", int'(done), 0);
    step();
    chk("R9 zero launch done", int'(done), 1);
    chk("R9 zero launch idle", int'(busy), 0);
    chk("R9 zero launch no offers", n_fire, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    launch_valid = 1'b0;
    launch_blocks = '0;
    launch_threads = '0;
    launch_cost = '0;
    retire = '0;
    asn_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_block_cap();
    t_warp_cap();
    t_budget();
    t_reject();
    t_zero();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule